// File: doc/BRIEF.md
# Sector Erase Batching Window

This block gathers several sector erase requests into a single erase batch. The first sector erase command opens an acceptance window. While the window is open, further sector erase commands add their sectors to a bitmap, and each one starts the window again. When the window runs out with no new sector command, the block closes the batch and issues a one-cycle erase-start pulse. The erase engine then uses the bitmap. A command of any other kind during the window throws the batch away and sends the bank back to array reading. An erase-suspend command is passed on as a request and leaves the batch intact.

The window length is counted in system clock cycles. By default it is derived from the clock frequency and a length in microseconds (50 µs), and it can be overridden directly. Commands reach the block already decoded. They take effect only in a cycle where the write-strobe rising-edge indication is high. The erase engine reports completion through `erase_done`.

The controller has three states. READ is array reading with no batch. WINDOW means the batch is collecting. ERASE means the window has closed and erasure is running. The transitions are as follows:
- open: READ to WINDOW on a sector command.
- extend: WINDOW to WINDOW on a sector command.
- abort: WINDOW to READ on any other command.
- lapse: WINDOW to ERASE when the timer expires.
- finish: ERASE to READ on `erase_done`.

Top module: `sector_erase_window`

## Requirements
- R1: While reset is asserted and right after it is released, `sect_map` is all zero and `win_closed`, `erase_start`, `abort_read` and `suspend_req` are 0.
- R2: A command is taken only in a cycle with `cmd_stb` high. The kind codes are 0 none, 1 sector erase, 2 erase suspend and 3 other. In READ, kinds 0, 2 and 3 have no effect. A sector erase opens the window and sets bit `sect_addr` of `sect_map`.
- R3: In WINDOW, each sector erase sets its bit. Bits already set stay set. Sectors may arrive in any order, a repeated sector is harmless, and every sector may be selected.
- R4: Suppose a sector command is accepted at clock edge k and no command arrives at edges k+1 to k+WIN_CYCLES. Then `erase_start` is high for exactly one cycle, between edges k+WIN_CYCLES and k+WIN_CYCLES+1. A sector command that arrives at any of those edges, including the last, is accepted and starts the count again.
- R5: `win_closed` is 0 in READ and WINDOW. It becomes 1 in the cycle that `erase_start` is high and stays 1 until `erase_done` is taken.
- R6: A kind-3 command in WINDOW clears `sect_map`, pulses `abort_read` for one cycle, returns to READ and produces no `erase_start`.
- R7: A kind-2 command in WINDOW or ERASE pulses `suspend_req` for one cycle after the edge. In WINDOW it keeps the bitmap and does not restart the window count.
- R8: In ERASE, sector erase and kind-3 commands are ignored: `sect_map` is unchanged and `abort_read` stays 0.
- R9: `erase_done` in ERASE clears `sect_map` and returns to READ, so `win_closed` reads 0. In READ and WINDOW, `erase_done` is ignored.
- R10: A sector number of NUM_SECT or above sets no bit. It is still accepted: it opens or extends the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_stb | input | 1 | Write-strobe rising-edge indication; qualifies the command |
| cmd_kind | input | 2 | Decoded command: 0 none, 1 sector erase, 2 suspend, 3 other |
| sect_addr | input | AW | Sector number for a sector erase, AW = clog2(NUM_SECT) |
| erase_done | input | 1 | Erase engine finished the batch |
| sect_map | output | NUM_SECT | Bitmap of sectors selected for erasure |
| erase_start | output | 1 | One-cycle pulse: batch closed, erase begins |
| win_closed | output | 1 | 0 while sectors may be added, 1 once erasure has started |
| abort_read | output | 1 | One-cycle pulse: batch discarded, back to array reading |
| suspend_req | output | 1 | One-cycle pulse: erase suspend requested |

## Verification
The bench builds the block with NUM_SECT = 6 and WIN_CYCLES = 12. A six-sector map still needs a 3-bit sector number, so the out-of-range numbers 6 and 7 can be driven. A 12-cycle window is short enough that random gaps between commands often straddle the lapse point, and that both the last-edge extension and the exact start cycle can be hit in directed cases. The random part runs thousands of cycles of mixed commands, completions and a reset in the middle of the run against a cycle model in the bench.

// File: rtl/sew_pkg.sv
`timescale 1ns/1ps
package sew_pkg;
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_SECT  = 2'd1,
        CMD_SUSP  = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_READ   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_ERASE  = 2'd2
    } st_e;
endpackage

// File: rtl/sew_window_timer.sv
`timescale 1ns/1ps
module sew_window_timer #(
    parameter int WIN_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic lapse
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || restart)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + CW'(1);
    end

    assign lapse = run && (cnt == LAST);

    initial begin
        assert (WIN_CYCLES >= 2) else $error("window must span at least two cycles");
    end

    // R4: count never passes the lapse point
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R4: an accepted sector command starts the count over
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/sew_sector_map.sv
`timescale 1ns/1ps
module sew_sector_map #(
    parameter int NUM_SECT = 16,
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [AW-1:0]       set_idx,
    input  logic                clr,
    output logic [NUM_SECT-1:0] map
);
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                map[i] <= 1'b0;
            else if (clr)
                map[i] <= 1'b0;
            else if (set_en && (set_idx == AW'(i)))
                map[i] <= 1'b1;
        end
    end

    // R6: a clear leaves the bitmap empty
    p_clr_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (map == '0));
    // R10: an out-of-range sector number leaves the bitmap as it was
    p_range_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr && (int'(set_idx) >= NUM_SECT)) |=> $stable(map));
    // R3: an in-range set never drops bits already selected
    p_set_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr) |=> ((map & $past(map)) == $past(map)));
endmodule

// File: rtl/sew_ctrl.sv
`timescale 1ns/1ps
module sew_ctrl
    import sew_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_stb,
    input  cmd_e cmd_kind,
    input  logic erase_done,
    input  logic lapse,
    output logic timer_run,
    output logic accept,
    output logic clr,
    output logic erase_start,
    output logic abort_read,
    output logic suspend_req,
    output logic win_closed
);
    st_e  st, nxt;
    logic start_n, abort_n, susp_n;
    logic is_sect, is_susp, is_other;

    assign is_sect  = cmd_stb && (cmd_kind == CMD_SECT);
    assign is_susp  = cmd_stb && (cmd_kind == CMD_SUSP);
    assign is_other = cmd_stb && (cmd_kind == CMD_OTHER);

    always_comb begin
        nxt     = st;
        accept  = 1'b0;
        clr     = 1'b0;
        start_n = 1'b0;
        abort_n = 1'b0;
        susp_n  = 1'b0;
        unique case (st)
            ST_READ: begin
                if (is_sect) begin
                    accept = 1'b1;
                    nxt    = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (is_sect) begin
                    accept = 1'b1;
                end else if (is_other) begin
                    clr     = 1'b1;
                    abort_n = 1'b1;
                    nxt     = ST_READ;
                end else begin
                    susp_n = is_susp;
                    if (lapse) begin
                        start_n = 1'b1;
                        nxt     = ST_ERASE;
                    end
                end
            end
            ST_ERASE: begin
                if (erase_done) begin
                    clr = 1'b1;
                    nxt = ST_READ;
                end else begin
                    susp_n = is_susp;
                end
            end
            default: nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_READ;
        else
            st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_start <= 1'b0;
            abort_read  <= 1'b0;
            suspend_req <= 1'b0;
        end else begin
            erase_start <= start_n;
            abort_read  <= abort_n;
            suspend_req <= susp_n;
        end
    end

    assign timer_run  = (st == ST_WINDOW);
    assign win_closed = (st == ST_ERASE);

    // R5: the start pulse coincides with a closed window
    p_start_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> win_closed);
    // R4: start is a single-cycle pulse
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);
    // R6: abort and start never coincide
    p_abort_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_start, abort_read}));
    // R6: after an abort the controller is back in read mode
    p_abort_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_read |-> (st == ST_READ));
endmodule

// File: rtl/sector_erase_window.sv
`timescale 1ns/1ps
module sector_erase_window
    import sew_pkg::*;
#(
    parameter int NUM_SECT   = 16,
    parameter int CLK_KHZ    = 100000,
    parameter int WIN_US     = 50,
    parameter int WIN_CYCLES = CLK_KHZ * WIN_US / 1000,
    localparam int AW        = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stb,
    input  logic [1:0]          cmd_kind,
    input  logic [AW-1:0]       sect_addr,
    input  logic                erase_done,
    output logic [NUM_SECT-1:0] sect_map,
    output logic                erase_start,
    output logic                win_closed,
    output logic                abort_read,
    output logic                suspend_req
);
    logic lapse, timer_run, accept, clr;

    sew_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (cmd_stb),
        .cmd_kind    (cmd_e'(cmd_kind)),
        .erase_done  (erase_done),
        .lapse       (lapse),
        .timer_run   (timer_run),
        .accept      (accept),
        .clr         (clr),
        .erase_start (erase_start),
        .abort_read  (abort_read),
        .suspend_req (suspend_req),
        .win_closed  (win_closed)
    );

    sew_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .restart (accept),
        .lapse   (lapse)
    );

    sew_sector_map #(.NUM_SECT(NUM_SECT), .AW(AW)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_idx (sect_addr),
        .clr     (clr),
        .map     (sect_map)
    );

    // R8: while erasing, the bitmap and the closed status hold until completion
    p_erase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_closed && !erase_done) |=> ($stable(sect_map) && win_closed));
    // R9: completion empties the bitmap and reopens read mode
    p_done_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_closed && erase_done) |=> (!win_closed && (sect_map == '0)));
    // R8: no abort pulse follows a cycle spent erasing
    p_no_abort_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_closed |=> !abort_read);
endmodule

// File: tb/sector_erase_window_test.sv
`timescale 1ns/1ps
module sector_erase_window_test;
    localparam int N   = 6;
    localparam int WIN = 12;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_stb = 1'b0;
    logic [1:0]    cmd_kind = 2'd0;
    logic [AW-1:0] sect_addr = '0;
    logic          erase_done = 1'b0;
    logic [N-1:0]  sect_map;
    logic          erase_start, win_closed, abort_read, suspend_req;

    int total = 0;
    int bad = 0;

    // bench-side cycle model
    int           m_st = 0;
    logic [N-1:0] m_map = '0;
    int           m_cnt = 0;
    logic         m_start = 1'b0, m_abort = 1'b0, m_susp = 1'b0;

    always #2.5 clk = ~clk;

    sector_erase_window #(.NUM_SECT(N), .WIN_CYCLES(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
        .sect_addr(sect_addr), .erase_done(erase_done), .sect_map(sect_map),
        .erase_start(erase_start), .win_closed(win_closed),
        .abort_read(abort_read), .suspend_req(suspend_req)
    );

    function automatic logic [N-1:0] add_sect(logic [N-1:0] mp, int a);
        logic [N-1:0] r = mp;
        if (a < N) r[a] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic mdl(input logic stb, input logic [1:0] k, input int a, input logic done);
        m_start = 1'b0; m_abort = 1'b0; m_susp = 1'b0;
        case (m_st)
            0: if (stb && k == 2'd1) begin
                   m_st = 1; m_cnt = 0; m_map = add_sect(m_map, a);
               end
            1: if (stb && k == 2'd1) begin
                   m_cnt = 0; m_map = add_sect(m_map, a);
               end else if (stb && k == 2'd3) begin
                   m_map = '0; m_st = 0; m_abort = 1'b1;
               end else begin
                   if (stb && k == 2'd2) m_susp = 1'b1;
                   if (m_cnt == WIN - 1) begin m_st = 2; m_start = 1'b1; end
                   else m_cnt++;
               end
            default: if (done) begin m_st = 0; m_map = '0; end
                     else if (stb && k == 2'd2) m_susp = 1'b1;
        endcase
    endtask

    task automatic compare();
        chk("R3 bitmap", 32'(sect_map), 32'(m_map));
        chk("R4 erase_start", 32'(erase_start), 32'(m_start));
        chk("R5 win_closed", 32'(win_closed), 32'(m_st == 2));
        chk("R6 abort_read", 32'(abort_read), 32'(m_abort));
        chk("R7 suspend_req", 32'(suspend_req), 32'(m_susp));
    endtask

    // drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic cyc(input logic stb, input logic [1:0] k, input int a, input logic done);
        cmd_stb = stb; cmd_kind = k; sect_addr = AW'(a); erase_done = done;
        @(posedge clk);
        mdl(stb, k, a, done);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_stb = 1'b0; cmd_kind = 2'd0; sect_addr = '0; erase_done = 1'b0;
        m_st = 0; m_map = '0; m_cnt = 0; m_start = 1'b0; m_abort = 1'b0; m_susp = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 map in reset", 32'(sect_map), 0);
        chk("R1 flags in reset", 32'({erase_start, win_closed, abort_read, suspend_req}), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        idle(1);
        chk("R1 after release", 32'({sect_map, erase_start, win_closed, abort_read, suspend_req}), 0);

        // R2: read mode ignores kinds 0,2,3 and unstrobed commands
        cyc(1'b1, 2'd3, 1, 1'b0);
        cyc(1'b1, 2'd2, 1, 1'b0);
        cyc(1'b1, 2'd0, 1, 1'b0);
        cyc(1'b0, 2'd1, 3, 1'b0);
        chk("R2 read ignores", 32'({sect_map, win_closed, abort_read, suspend_req}), 0);
        cyc(1'b1, 2'd1, 3, 1'b0);
        chk("R2 window opens", 32'(sect_map), 32'h08);

        // R3: any order, repeats harmless
        cyc(1'b1, 2'd1, 5, 1'b0);
        idle(2);
        cyc(1'b1, 2'd1, 0, 1'b0);
        cyc(1'b1, 2'd1, 3, 1'b0);
        chk("R3 batch", 32'(sect_map), 32'h29);

        // R10: out-of-range number sets nothing but restarts the window
        cyc(1'b1, 2'd1, 7, 1'b0);
        chk("R10 no bit", 32'(sect_map), 32'h29);
        idle(WIN - 1);
        chk("R4 open before lapse", 32'({erase_start, win_closed}), 0);
        idle(1);
        chk("R4 start at lapse", 32'(erase_start), 1);
        chk("R5 closed at start", 32'(win_closed), 1);
        idle(1);
        chk("R4 single pulse", 32'(erase_start), 0);

        // R8: erasing ignores sector and other commands; R7 suspend passes
        cyc(1'b1, 2'd1, 1, 1'b0);
        cyc(1'b1, 2'd3, 0, 1'b0);
        chk("R8 map held", 32'(sect_map), 32'h29);
        chk("R8 no abort", 32'(abort_read), 0);
        cyc(1'b1, 2'd2, 0, 1'b0);
        chk("R7 suspend in erase", 32'(suspend_req), 1);
        chk("R7 map kept", 32'(sect_map), 32'h29);

        // R9: completion
        cyc(1'b0, 2'd0, 0, 1'b1);
        chk("R9 cleared", 32'({sect_map, win_closed}), 0);

        // R6: abort in window
        cyc(1'b1, 2'd1, 2, 1'b1);
        chk("R9 done ignored in window", 32'(sect_map), 32'h04);
        cyc(1'b1, 2'd3, 0, 1'b0);
        chk("R6 map cleared", 32'(sect_map), 0);
        chk("R6 abort pulse", 32'(abort_read), 1);
        idle(WIN + 2);
        chk("R6 no start", 32'({erase_start, win_closed, abort_read}), 0);

        // R7: suspend in window keeps the count running; R4 last-edge extension
        cyc(1'b1, 2'd1, 4, 1'b0);
        idle(4);
        cyc(1'b1, 2'd2, 0, 1'b0);
        chk("R7 suspend in window", 32'(suspend_req), 1);
        chk("R7 bitmap kept", 32'(sect_map), 32'h10);
        idle(WIN - 6);
        chk("R7 still open", 32'(win_closed), 0);
        cyc(1'b1, 2'd1, 1, 1'b0);
        chk("R4 last edge accepted", 32'({sect_map, win_closed}), 32'h12 << 1);
        idle(WIN);
        chk("R4 start after extension", 32'(erase_start), 1);
        cyc(1'b0, 2'd0, 0, 1'b1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic stb;
            logic [1:0] k;
            r = int'($urandom % 40);
            stb = 1'b1;
            if (r < 3) k = 2'd1;
            else if (r == 3) k = 2'd2;
            else if (r == 4) k = 2'd3;
            else if (r == 5) k = 2'd0;
            else begin stb = 1'b0; k = 2'($urandom % 4); end
            if (i == 2000) do_reset();
            cyc(stb, k, int'($urandom % 8), ($urandom % 25) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule